// File: doc/BRIEF.md
# Serial Programming Target Command Decoder

This block is the target side of a four-byte serial programming link. While the host keeps the target out of normal operation (`run_mode` low), it receives instructions on `mosi`, clocked by a host-driven `sck`. It answers on `miso`. Both serial signals are oversampled in the local `clk` domain. Every instruction is exactly four bytes long and is sent MSB first: an opcode, two address bytes (high then low) and a data byte. The opcode is acted on once the last bit of the frame has arrived.

A session must first be opened with the enable instruction. The target echoes back each byte one byte later, so a host can see that it is in step: while it shifts the third byte of the enable instruction, it gets back the sync byte it sent as the second. Flash is written through a page buffer of 64 sixteen-bit words. Each half of a word is loaded by its own instruction. A page-write instruction then copies the whole buffer into one flash page. EEPROM is written one byte at a time: the location is first set to the erased value and then receives the new byte. Each write holds `busy` high for a fixed number of clock cycles. During that time only reads and polls are served.

The memories are small inferred arrays. Their sizes and the write time are parameters.

Top module: `sprog_target`

## Requirements
- R1: `mosi` is sampled on each rising edge of `sck`, and `miso` changes only after a falling edge of `sck`. Bytes travel MSB first in both directions.
- R2: A frame is exactly four bytes. On `miso` the host receives 0x00 during byte 0, the received byte 0 during byte 1, and the received byte 1 during byte 2. During byte 3 it receives the received byte 2, unless R9/R10 give a different value.
- R3: The enable instruction (opcode 0xA5) opens the session only when its byte 1 is 0x53. Because of R2, 0x53 is echoed while byte 2 is shifted in.
- R4: Until the session is open, every instruction other than enable is ignored. A poll then returns the echo of byte 2.
- R5: While `run_mode` is high, the session is closed and the bit and byte counters return to the start of a frame, so a partly sent frame is discarded.
- R6: Load-low (0x41) and load-high (0x49) write the data byte into the low or high half of the page buffer word addressed by byte 2 bits [5:0].
- R7: Page write (0x4C) copies all buffer words into flash page ({byte1,byte2} >> 6). The buffer keeps its contents afterwards.
- R8: EEPROM write (0xC0) targets address {byte1,byte2} mod 2^EE_AW. The location reads 0xFF during the write and holds the data byte once it completes.
- R9: Flash read-low (0x20), read-high (0x28) and EEPROM read (0xA0) return the addressed byte during byte 3. The flash word address is {byte1,byte2}.
- R10: Poll (0xF0) in an open session returns 0x01 during byte 3 while a write is in progress and 0x00 otherwise.
- R11: `busy` rises the cycle after a write is accepted and stays high for WR_CYCLES cycles. While it is high, load and write instructions are ignored.
- R12: Unknown opcodes do nothing and still take four bytes.
- R13: After reset, `miso` and `busy` are low and the session is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock that oversamples the serial link |
| rst | input | 1 | Synchronous active-high reset |
| run_mode | input | 1 | High while the target runs normally; low allows programming |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| busy | output | 1 | High while a flash page or EEPROM write is in progress |

## Verification
The checker assumes that each `sck` phase lasts at least four `clk` cycles. This lets the synchronized edges, the registered memory reads and the `miso` update finish within one phase. It also assumes `mosi` is steady across each rising edge. The bench holds every `sck` phase for six cycles and changes `mosi` only at the start of a low phase. `run_mode` is pulsed only between frames, or on purpose after a partial frame. Instructions sent during a write are timed so that their last bit arrives while `busy` is certainly still high.

// File: rtl/sprog_pkg.sv
package sprog_pkg;
  localparam logic [7:0] OP_ENABLE     = 8'hA5;
  localparam logic [7:0] OP_LOAD_LO    = 8'h41;
  localparam logic [7:0] OP_LOAD_HI    = 8'h49;
  localparam logic [7:0] OP_WRITE_PAGE = 8'h4C;
  localparam logic [7:0] OP_READ_LO    = 8'h20;
  localparam logic [7:0] OP_READ_HI    = 8'h28;
  localparam logic [7:0] OP_EE_WRITE   = 8'hC0;
  localparam logic [7:0] OP_EE_READ    = 8'hA0;
  localparam logic [7:0] OP_POLL       = 8'hF0;
  localparam logic [7:0] SYNC_BYTE     = 8'h53;
  localparam logic [7:0] ERASED_BYTE   = 8'hFF;

  typedef enum logic {JOB_FLASH, JOB_EEPROM} job_e;
endpackage

// File: rtl/sprog_sync.sv
module sprog_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s
);
  logic [STAGES:0]   sck_q;
  logic [STAGES-1:0] mosi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q  <= '0;
      mosi_q <= '0;
    end else begin
      sck_q  <= {sck_q[STAGES-1:0], sck};
      mosi_q <= {mosi_q[STAGES-2:0], mosi};
    end
  end

  // mosi_q[STAGES-1] has the same latency as sck_q[STAGES-1]
  assign sck_rise = sck_q[STAGES-1] & ~sck_q[STAGES];
  assign sck_fall = ~sck_q[STAGES-1] & sck_q[STAGES];
  assign mosi_s   = mosi_q[STAGES-1];
endmodule

// File: rtl/sprog_shifter.sv
module sprog_shifter (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            rise,
  input  logic            fall,
  input  logic            mosi_s,
  input  logic [7:0]      last_tx,
  output logic            frame_done,
  output logic [3:0][7:0] frame_bytes,
  output logic            miso
);
  logic [4:0] bit_cnt;
  logic [7:0] rx_sh;
  logic [7:0] tx_sh;
  logic [7:0] rx_next;
  logic [7:0] tx_val;
  logic       load_pend;
  logic [1:0] next_idx;

  assign rx_next = {rx_sh[6:0], mosi_s};

  // byte to present while frame byte next_idx is shifted in
  always_comb begin
    case (next_idx)
      2'd0:    tx_val = 8'h00;
      2'd1:    tx_val = frame_bytes[0];
      2'd2:    tx_val = frame_bytes[1];
      default: tx_val = last_tx;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      bit_cnt    <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      load_pend  <= 1'b0;
      next_idx   <= '0;
      frame_done <= 1'b0;
      miso       <= 1'b0;
      if (rst) frame_bytes <= '0;
    end else begin
      frame_done <= 1'b0;
      if (rise) begin
        rx_sh   <= rx_next;
        bit_cnt <= bit_cnt + 5'd1;
        if (bit_cnt[2:0] == 3'd7) begin
          frame_bytes[bit_cnt[4:3]] <= rx_next;
          load_pend  <= 1'b1;
          next_idx   <= bit_cnt[4:3] + 2'd1;
          frame_done <= (bit_cnt[4:3] == 2'd3);
        end
      end else if (fall) begin
        if (load_pend) begin
          miso      <= tx_val[7];
          tx_sh     <= {tx_val[6:0], 1'b0};
          load_pend <= 1'b0;
        end else begin
          miso  <= tx_sh[7];
          tx_sh <= {tx_sh[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/sprog_mem.sv
module sprog_mem #(
  parameter int PAGE_AW = 6,
  parameter int PSEL_W  = 3,
  parameter int EE_AW   = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      pb_we,
  input  logic                      pb_hi,
  input  logic [PAGE_AW-1:0]        pb_waddr,
  input  logic [7:0]                pb_din,
  input  logic                      cp_en,
  input  logic [PAGE_AW-1:0]        cp_idx,
  input  logic [PSEL_W-1:0]         cp_page,
  input  logic [PSEL_W+PAGE_AW-1:0] fl_raddr,
  output logic [15:0]               fl_rdata,
  input  logic                      ee_we,
  input  logic [EE_AW-1:0]          ee_waddr,
  input  logic [7:0]                ee_din,
  input  logic [EE_AW-1:0]          ee_raddr,
  output logic [7:0]                ee_rdata
);
  localparam int FL_AW    = PSEL_W + PAGE_AW;
  localparam int FL_WORDS = 1 << FL_AW;
  localparam int PG_WORDS = 1 << PAGE_AW;
  localparam int EE_BYTES = 1 << EE_AW;

  // page buffer: one byte-wide array per half, read during the copy
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [7:0] buf_mem [PG_WORDS];
    logic [7:0] rd_q;
    always_ff @(posedge clk) begin
      if (pb_we && (pb_hi == 1'(h))) buf_mem[pb_waddr] <= pb_din;
      rd_q <= buf_mem[cp_idx];
    end
  end

  logic             cp_v_q;
  logic [FL_AW-1:0] cp_addr_q;
  logic [15:0]      flash_mem [FL_WORDS];
  logic [7:0]       ee_mem [EE_BYTES];

  always_ff @(posedge clk) begin
    if (rst) cp_v_q <= 1'b0;
    else     cp_v_q <= cp_en;
    cp_addr_q <= {cp_page, cp_idx};
  end

  always_ff @(posedge clk) begin
    if (cp_v_q) flash_mem[cp_addr_q] <= {g_half[1].rd_q, g_half[0].rd_q};
    fl_rdata <= flash_mem[fl_raddr];
  end

  always_ff @(posedge clk) begin
    if (ee_we) ee_mem[ee_waddr] <= ee_din;
    ee_rdata <= ee_mem[ee_raddr];
  end
endmodule

// File: rtl/sprog_target.sv
module sprog_target import sprog_pkg::*; #(
  parameter int SYNC_STAGES = 2,
  parameter int PAGE_AW     = 6,
  parameter int PSEL_W      = 3,
  parameter int EE_AW       = 6,
  parameter int WR_CYCLES   = 800
) (
  input  logic clk,
  input  logic rst,
  input  logic run_mode,
  input  logic sck,
  input  logic mosi,
  output logic miso,
  output logic busy
);
  localparam int FL_AW    = PSEL_W + PAGE_AW;
  localparam int PG_WORDS = 1 << PAGE_AW;
  localparam int CNT_W    = $clog2(WR_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WR_CYCLES - 1);
  localparam logic [CNT_W-1:0] CP_LIMIT = CNT_W'(PG_WORDS);

  logic            sck_rise, sck_fall, mosi_s;
  logic            frame_done;
  logic [3:0][7:0] frame_bytes;
  logic [7:0]      last_tx;
  logic [7:0]      op;
  logic [15:0]     addr16;
  logic            op_is_enable;
  logic            allowed;
  logic            pb_we, fl_start, ee_start, start_any;
  logic            enabled_q, busy_q;
  logic [CNT_W-1:0] cnt_q;
  job_e            job_q;
  logic [PSEL_W-1:0] page_q;
  logic [EE_AW-1:0]  ee_addr_q;
  logic [7:0]        ee_data_q;
  logic              cp_en, ee_we;
  logic [7:0]        ee_din;
  logic [15:0]       fl_rdata;
  logic [7:0]        ee_rdata;
  logic              unused_bits;

  sprog_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck(sck), .mosi(mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s)
  );

  sprog_shifter u_shift (
    .clk(clk), .rst(rst), .clr(run_mode), .rise(sck_rise), .fall(sck_fall),
    .mosi_s(mosi_s), .last_tx(last_tx), .frame_done(frame_done),
    .frame_bytes(frame_bytes), .miso(miso)
  );

  assign op          = frame_bytes[0];
  assign addr16      = {frame_bytes[1], frame_bytes[2]};
  assign unused_bits = ^addr16[15:FL_AW];

  assign op_is_enable = (op == OP_ENABLE);
  assign allowed      = enabled_q & ~busy_q;
  assign pb_we        = frame_done & allowed & ((op == OP_LOAD_LO) | (op == OP_LOAD_HI));
  assign fl_start     = frame_done & allowed & (op == OP_WRITE_PAGE);
  assign ee_start     = frame_done & allowed & (op == OP_EE_WRITE);
  assign start_any    = fl_start | ee_start;

  always_ff @(posedge clk) begin
    if (rst || run_mode)
      enabled_q <= 1'b0;
    else if (frame_done && !busy_q && op_is_enable && frame_bytes[1] == SYNC_BYTE)
      enabled_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      job_q     <= JOB_FLASH;
      page_q    <= '0;
      ee_addr_q <= '0;
      ee_data_q <= '0;
    end else if (start_any) begin
      busy_q    <= 1'b1;
      cnt_q     <= '0;
      job_q     <= fl_start ? JOB_FLASH : JOB_EEPROM;
      page_q    <= addr16[FL_AW-1:PAGE_AW];
      ee_addr_q <= addr16[EE_AW-1:0];
      ee_data_q <= frame_bytes[3];
    end else if (busy_q) begin
      if (cnt_q == CNT_LAST) busy_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // page copy: one buffer word per cycle at the start of the busy window
  assign cp_en  = busy_q && (job_q == JOB_FLASH) && (cnt_q < CP_LIMIT);
  // EEPROM: erase on the first busy cycle, final data on the last
  assign ee_we  = busy_q && (job_q == JOB_EEPROM) && (cnt_q == '0 || cnt_q == CNT_LAST);
  assign ee_din = (cnt_q == CNT_LAST) ? ee_data_q : ERASED_BYTE;

  sprog_mem #(.PAGE_AW(PAGE_AW), .PSEL_W(PSEL_W), .EE_AW(EE_AW)) u_mem (
    .clk(clk), .rst(rst),
    .pb_we(pb_we), .pb_hi(op == OP_LOAD_HI), .pb_waddr(frame_bytes[2][PAGE_AW-1:0]),
    .pb_din(frame_bytes[3]),
    .cp_en(cp_en), .cp_idx(cnt_q[PAGE_AW-1:0]), .cp_page(page_q),
    .fl_raddr(addr16[FL_AW-1:0]), .fl_rdata(fl_rdata),
    .ee_we(ee_we), .ee_waddr(ee_addr_q), .ee_din(ee_din),
    .ee_raddr(addr16[EE_AW-1:0]), .ee_rdata(ee_rdata)
  );

  always_comb begin
    last_tx = frame_bytes[2];
    if (enabled_q) begin
      case (op)
        OP_READ_LO: last_tx = fl_rdata[7:0];
        OP_READ_HI: last_tx = fl_rdata[15:8];
        OP_EE_READ: last_tx = ee_rdata;
        OP_POLL:    last_tx = {7'b0, busy_q};
        default:    last_tx = frame_bytes[2];
      endcase
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/sprog_target_chk.sv
module sprog_target_chk (
  input logic clk,
  input logic rst,
  input logic run_mode,
  input logic sck_fall,
  input logic miso,
  input logic frame_done,
  input logic op_is_enable,
  input logic enabled,
  input logic pb_we,
  input logic start,
  input logic busy
);
  // R1: miso moves only after a falling sck edge
  p_miso_on_fall_r1: assert property (@(posedge clk) disable iff (rst)
    (!sck_fall && !run_mode) |=> $stable(miso));

  // R2: a frame completes as a single-cycle event
  p_frame_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  // R4: a closed session accepts nothing but enable
  p_locked_r4: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !enabled && !op_is_enable) |-> !(pb_we || start));

  // R5: run mode closes the session
  p_run_closes_r5: assert property (@(posedge clk) disable iff (rst)
    run_mode |=> !enabled);

  // R11: no load or write is accepted while busy
  p_busy_blocks_r11: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(pb_we || start));

  // R11: an accepted write raises busy next cycle
  p_start_busy_r11: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
endmodule

bind sprog_target sprog_target_chk u_chk (
  .clk(clk), .rst(rst), .run_mode(run_mode), .sck_fall(sck_fall), .miso(miso),
  .frame_done(frame_done), .op_is_enable(op_is_enable), .enabled(enabled_q),
  .pb_we(pb_we), .start(start_any), .busy(busy_q)
);

// File: tb/sprog_target_tb.sv
module sprog_target_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int WR_CYCLES  = 800;
  localparam int PAGE_AW    = 6;
  localparam int PSEL_W     = 3;
  localparam int EE_AW      = 6;
  localparam int FL_WORDS   = 1 << (PAGE_AW + PSEL_W);
  localparam int PG_WORDS   = 1 << PAGE_AW;
  localparam int EE_BYTES   = 1 << EE_AW;

  logic clk = 1'b0, rst = 1'b1, run_mode = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, busy;
  int total = 0, bad = 0;
  logic [7:0] rsp [4];

  logic [7:0]  pbm_lo [PG_WORDS];
  logic [7:0]  pbm_hi [PG_WORDS];
  logic        pbm_v  [PG_WORDS];
  logic [15:0] flm    [FL_WORDS];
  logic        flm_v  [FL_WORDS];
  logic [7:0]  eem    [EE_BYTES];
  logic        eem_v  [EE_BYTES];

  always #(CLK_PERIOD/2) clk = ~clk;

  sprog_target #(.WR_CYCLES(WR_CYCLES), .PAGE_AW(PAGE_AW), .PSEL_W(PSEL_W), .EE_AW(EE_AW)) u_dut (
    .clk(clk), .rst(rst), .run_mode(run_mode), .sck(sck), .mosi(mosi), .miso(miso), .busy(busy)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // full four-byte frame, MSB first; miso read at the end of each low phase
  task automatic frame(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c, input logic [7:0] d);
    logic [7:0] tx [4];
    tx[0] = a; tx[1] = b; tx[2] = c; tx[3] = d;
    for (int i = 0; i < 4; i++) begin
      for (int j = 7; j >= 0; j--) begin
        mosi = tx[i][j];
        repeat (HALF) @(negedge clk);
        rsp[i][j] = miso;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
        sck = 1'b0;
      end
    end
  endtask

  // frame plus echo checks (R1 and R2); result byte left in rsp[3]
  task automatic cmd(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c, input logic [7:0] d);
    frame(a, b, c, d);
    chk("R2 byte0 idle", {8'h0, rsp[0]}, 16'h0000);
    chk("R1 R2 echo op", {8'h0, rsp[1]}, {8'h0, a});
    chk("R2 echo byte1", {8'h0, rsp[2]}, {8'h0, b});
  endtask

  task automatic junk_bits(input int n);
    for (int k = 0; k < n; k++) begin
      mosi = 1'($urandom);
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic pulse_run();
    repeat (2) @(negedge clk);
    run_mode = 1'b1;
    repeat (4) @(negedge clk);
    run_mode = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 8; k++) begin
      cmd(8'hF0, 8'h00, 8'h00, 8'h00);
      if (rsp[3] == 8'h00) break;
    end
    chk("R10 poll reaches idle", {8'h0, rsp[3]}, 16'h0000);
  endtask

  task automatic ee_write(input logic [EE_AW-1:0] ad, input logic [7:0] dv);
    cmd(8'hC0, 8'h00, 8'(ad), dv);
    eem[ad] = dv; eem_v[ad] = 1'b1;
  endtask

  task automatic ee_check(input logic [EE_AW-1:0] ad, input string tag);
    cmd(8'hA0, 8'h00, 8'(ad), 8'h00);
    if (eem_v[ad]) chk(tag, {8'h0, rsp[3]}, {8'h0, eem[ad]});
  endtask

  task automatic fl_check(input int w);
    cmd(8'h20, 8'(w >> 8), 8'(w), 8'h00);
    chk("R9 flash read low", {8'h0, rsp[3]}, {8'h0, flm[w][7:0]});
    cmd(8'h28, 8'(w >> 8), 8'(w), 8'h00);
    chk("R9 flash read high", {8'h0, rsp[3]}, {8'h0, flm[w][15:8]});
  endtask

  task automatic page_write(input int p);
    cmd(8'h4C, 8'(p >> 2), {2'(p), 6'b0}, 8'h00);
    for (int i = 0; i < PG_WORDS; i++)
      if (pbm_v[i]) begin
        flm[p*PG_WORDS + i]   = {pbm_hi[i], pbm_lo[i]};
        flm_v[p*PG_WORDS + i] = 1'b1;
      end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < PG_WORDS; i++) pbm_v[i] = 1'b0;
    for (int i = 0; i < FL_WORDS; i++) flm_v[i] = 1'b0;
    for (int i = 0; i < EE_BYTES; i++) eem_v[i] = 1'b0;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R13 miso after reset", {15'h0, miso}, 16'h0000);
    chk("R13 busy after reset", {15'h0, busy}, 16'h0000);
    run_mode = 1'b0;
    repeat (3) @(negedge clk);

    // R4/R13: closed session, poll echoes byte 2
    cmd(8'hF0, 8'h00, 8'h77, 8'h00);
    chk("R4 R13 poll while closed", {8'h0, rsp[3]}, 16'h0077);
    // R3: wrong sync byte keeps session closed
    cmd(8'hA5, 8'h52, 8'h00, 8'h00);
    cmd(8'hF0, 8'h00, 8'h77, 8'h00);
    chk("R3 bad sync stays closed", {8'h0, rsp[3]}, 16'h0077);
    // R3: proper enable echoes 0x53 during byte 2
    cmd(8'hA5, 8'h53, 8'h11, 8'h22);
    chk("R3 sync echo", {8'h0, rsp[2]}, 16'h0053);
    chk("R2 enable last byte echo", {8'h0, rsp[3]}, 16'h0011);
    cmd(8'hF0, 8'h00, 8'h77, 8'h00);
    chk("R10 poll idle", {8'h0, rsp[3]}, 16'h0000);

    // R8/R11: EEPROM write, erase visible, write during busy ignored
    ee_write(6'd5, 8'h3C);
    cmd(8'hA0, 8'h00, 8'h05, 8'h00);
    chk("R8 erased during write", {8'h0, rsp[3]}, 16'h00FF);
    cmd(8'hC0, 8'h00, 8'h07, 8'h99);   // ignored, R11
    wait_idle();
    ee_check(6'd5, "R8 eeprom data after write");
    cmd(8'hA0, 8'h00, 8'h07, 8'h00);
    chk("R11 write during busy ignored", {8'h0, rsp[3] == 8'h99}, 16'h0000);

    // R11: busy length
    ee_write(6'd7, 8'h5A);
    n = 0;
    while (busy === 1'b1 && n < 5000) begin @(negedge clk); n++; end
    chk("R11 busy duration", 16'(n), 16'(WR_CYCLES - HALF + 4));
    ee_check(6'd7, "R8 eeprom second write");

    // R5: run-mode pulse closes session; writes then ignored
    pulse_run();
    cmd(8'hC0, 8'h00, 8'h05, 8'h99);
    cmd(8'hF0, 8'h00, 8'h66, 8'h00);
    chk("R5 session closed after run pulse", {8'h0, rsp[3]}, 16'h0066);
    // R5: partial frame discarded by run pulse
    junk_bits(13);
    pulse_run();
    cmd(8'hA5, 8'h53, 8'h00, 8'h00);
    chk("R5 realigned enable echo", {8'h0, rsp[2]}, 16'h0053);
    ee_check(6'd5, "R4 closed write ignored");

    // R12: unknown opcode keeps framing
    cmd(8'h13, 8'h24, 8'h35, 8'h46);
    chk("R12 unknown op echo", {8'h0, rsp[3]}, 16'h0035);
    cmd(8'hF0, 8'h00, 8'h00, 8'h00);
    chk("R12 aligned after unknown", {8'h0, rsp[3]}, 16'h0000);

    // R6/R7: load 16 random words, halves in random order
    for (int i = 0; i < 16; i++) begin
      logic [7:0] lo, hi;
      lo = 8'($urandom); hi = 8'($urandom);
      if ($urandom % 2 == 0) begin
        cmd(8'h41, 8'h00, 8'(i), lo); cmd(8'h49, 8'h00, 8'(i), hi);
      end else begin
        cmd(8'h49, 8'h00, 8'(i), hi); cmd(8'h41, 8'h00, 8'(i), lo);
      end
      pbm_lo[i] = lo; pbm_hi[i] = hi; pbm_v[i] = 1'b1;
    end
    page_write(2);
    chk("R11 busy after page write", {15'h0, busy}, 16'h0001);
    cmd(8'hF0, 8'h00, 8'h00, 8'h00);
    chk("R10 poll busy", {8'h0, rsp[3]}, 16'h0001);
    cmd(8'h41, 8'h00, 8'h00, 8'hEE);    // R11: ignored load
    wait_idle();
    for (int i = 0; i < 16; i++) fl_check(2*PG_WORDS + i);

    // R7: buffer retained, second page gets the same words
    page_write(5);
    wait_idle();
    for (int i = 0; i < 4; i++) fl_check(5*PG_WORDS + i);

    // R8/R9: random EEPROM traffic
    for (int k = 0; k < 6; k++) begin
      ee_write(6'($urandom), 8'($urandom));
      wait_idle();
    end
    for (int a = 0; a < EE_BYTES; a++)
      if (eem_v[a]) ee_check(6'(a), "R9 eeprom readback");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule